// File: doc/BRIEF.md
# Transmit Descriptor Ring Engine

This block walks a circular ring of transmit descriptors kept in shared memory and feeds the frames they describe to a frame-transmit interface. Each descriptor is two 32-bit words. The first is an info word holding an ownership bit, two frame-boundary flags and a length. The second is a buffer pointer. The engine reads the info word of the current slot. If the hardware owns the slot, the engine reads the pointer, hands the pointer and length to the transmit side, and waits for the frame to complete. It then writes the info word back with completion status and with ownership returned to software, and moves straight on to the next slot.

When the engine meets a slot that software still owns, it stops there and keeps that index. It checks the slot again after a programmable idle interval, or at once when software writes a kick command. A small write-only register port sets the controls:

| Address | Contents |
|---|---|
| 0 | Control: enable in bit 0, ring size in bits [23:16] |
| 1 | Ring base address |
| 2 | Idle re-poll interval |
| 3 | Command: clear interrupt, kick |

Each completed frame sets a sticky interrupt flag.

Top module: `txring_engine`

## Requirements
- R1: After reset `memReq`, `memWe`, `frmValid` and `txIrq` are low, the ring index is 0 and the engine does nothing until it is enabled.
- R2: Slot i sits at base + 8*i, where the base is written at register address 1. The info word is at that address and the pointer word at +4. When info bit 31 is 1, the engine reads the pointer, then drives `frmAddr` = pointer and `frmLen` = info[10:0] with `frmValid` until `frmReady`, and then waits for `frmDone`.
- R3: After `frmDone`, the engine writes the info word back to the same address. In that write bit 31 is 0 and bits [19:16] are replaced by `frmStatus`: bit 16 dropped, bit 17 deferred, bit 18 late collision, bit 19 underflow. All other bits (including flags 30 and 29 and the length) are unchanged. The engine then fetches the next slot without waiting.
- R4: An info word with bit 31 = 0 causes no pointer read, no frame and no write. The index stays on that slot.
- R5: The index advances by one after each write-back. It returns to 0 when it reaches the ring size held in control bits [23:16], so a slot at that index is never used.
- R6: After stopping on a software-owned slot, the engine waits the idle interval, in clock cycles (register address 2, bits [15:0]), before fetching again. It re-fetches by itself when the interval runs out.
- R7: Writing register address 3 with bit 1 = 1 makes the engine fetch the current slot without waiting for the interval.
- R8: While control bit 0 is 0, no new descriptor fetch starts. When bit 0 goes from 0 to 1, the index restarts at 0 and a fetch starts at once.
- R9: `txIrq` is set by each completed write-back. It stays set until register address 3 is written with bit 0 = 1.
- R10: `memReq`, `memWe`, `memAddr` and `memWData` hold until `memAck`. `frmValid`, `frmAddr` and `frmLen` hold until `frmReady`. `memReq` and `frmValid` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register address |
| regWrData | input | 32 | Register write data |
| memReq | output | 1 | Memory access request |
| memWe | output | 1 | Memory access is a write |
| memAddr | output | ADDR_W | Memory byte address |
| memWData | output | 32 | Memory write data |
| memRData | input | 32 | Memory read data, valid with memAck |
| memAck | input | 1 | Memory access done, one-cycle pulse |
| frmValid | output | 1 | Frame request valid |
| frmAddr | output | ADDR_W | Frame buffer address |
| frmLen | output | LEN_W | Frame length in bytes |
| frmReady | input | 1 | Frame request accepted |
| frmDone | input | 1 | Frame finished, one-cycle pulse |
| frmStatus | input | 4 | Completion status, valid with frmDone |
| txIrq | output | 1 | Sticky transmit-complete flag |

## Verification
The assertions assume the following about the inputs:

- `memAck` is a one-cycle pulse that only answers a pending `memReq`.
- `frmReady` comes only while `frmValid` is high.
- `frmDone` arrives once per accepted frame.
- Software does not move the ring base or size while the engine is walking the ring.

The bench's memory and frame responders keep to these rules. They answer each request with a single pulse one cycle later and report completion a fixed few cycles after acceptance. Register changes are made only while the engine sits idle on a software-owned slot or is disabled.

// File: rtl/txr_pkg.sv
package txr_pkg;

  localparam int WORD_W   = 32;
  localparam int OWN_BIT  = 31;
  localparam int STAT_LSB = 16;
  localparam int STAT_W   = 4;
  localparam int CNT_LSB  = 16;
  localparam int EN_BIT   = 0;
  localparam int CLR_BIT  = 0;
  localparam int KICK_BIT = 1;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_INFO,
    ST_RD_PTR,
    ST_SEND,
    ST_WAIT,
    ST_WB
  } txrState_e;

  typedef struct packed {
    logic fetchStart;
    logic latchInfo;
    logic latchPtr;
    logic mergeStatus;
    logic advance;
    logic selPtr;
    logic timerRun;
  } txrStrobe_t;

endpackage

// File: rtl/txr_datapath.sv
module txr_datapath
  import txr_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 8,
  parameter int LEN_W  = 11,
  parameter int TMR_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [1:0]        regAddr,
  input  logic [WORD_W-1:0] regWrData,
  input  logic [WORD_W-1:0] memRData,
  input  logic [STAT_W-1:0] frmStatus,
  input  txrStrobe_t        stb,
  output logic              engEnable,
  output logic              pollDue,
  output logic              infoOwn,
  output logic [ADDR_W-1:0] memAddr,
  output logic [WORD_W-1:0] memWData,
  output logic [ADDR_W-1:0] frmAddr,
  output logic [LEN_W-1:0]  frmLen,
  output logic              txIrq
);

  localparam int OFF_W = IDX_W + 3;

  logic              enReg, prevEn, enRise;
  logic [IDX_W-1:0]  ringCount, idx, idxNext;
  logic [ADDR_W-4:0] ringBase;
  logic [TMR_W-1:0]  pollRate, timer;
  logic              kickPend, irqReg;
  logic [WORD_W-1:0] infoReg, ptrReg;
  logic [OFF_W-1:0]  descOff;
  logic              cmdWr;

  assign enRise  = enReg & ~prevEn;
  assign cmdWr   = regWrEn && (regAddr == 2'd3);
  assign idxNext = idx + IDX_W'(1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enReg     <= 1'b0;
      prevEn    <= 1'b0;
      ringCount <= '0;
      ringBase  <= '0;
      pollRate  <= '0;
    end else begin
      prevEn <= enReg;
      if (regWrEn) begin
        case (regAddr)
          2'd0: begin
            enReg     <= regWrData[EN_BIT];
            ringCount <= regWrData[CNT_LSB +: IDX_W];
          end
          2'd1: ringBase <= regWrData[ADDR_W-1:3];
          2'd2: pollRate <= regWrData[TMR_W-1:0];
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idx      <= '0;
      kickPend <= 1'b0;
      timer    <= '0;
      irqReg   <= 1'b0;
    end else begin
      if (enRise)
        idx <= '0;
      else if (stb.advance)
        idx <= (idxNext == ringCount) ? '0 : idxNext;

      if (enRise || (cmdWr && regWrData[KICK_BIT]))
        kickPend <= 1'b1;
      else if (stb.fetchStart)
        kickPend <= 1'b0;

      if (!stb.timerRun)
        timer <= pollRate;
      else if (timer != '0)
        timer <= timer - TMR_W'(1);

      if (stb.advance)
        irqReg <= 1'b1;
      else if (cmdWr && regWrData[CLR_BIT])
        irqReg <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      infoReg <= '0;
      ptrReg  <= '0;
    end else begin
      if (stb.latchInfo)
        infoReg <= memRData;
      else if (stb.mergeStatus) begin
        infoReg[OWN_BIT]                 <= 1'b0;
        infoReg[STAT_LSB +: STAT_W]      <= frmStatus;
      end
      if (stb.latchPtr)
        ptrReg <= memRData;
    end
  end

  assign descOff   = {idx, stb.selPtr, 2'b00};
  assign memAddr   = {ringBase, 3'b000} + ADDR_W'(descOff);
  assign memWData  = infoReg;
  assign frmAddr   = ptrReg[ADDR_W-1:0];
  assign frmLen    = infoReg[LEN_W-1:0];
  assign engEnable = enReg;
  assign pollDue   = kickPend || (timer == '0);
  assign infoOwn   = memRData[OWN_BIT];
  assign txIrq     = irqReg;

endmodule

// File: rtl/txr_control.sv
module txr_control
  import txr_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       engEnable,
  input  logic       pollDue,
  input  logic       infoOwn,
  input  logic       memAck,
  input  logic       frmReady,
  input  logic       frmDone,
  output logic       memReq,
  output logic       memWe,
  output logic       frmValid,
  output txrStrobe_t stb
);

  txrState_e state, stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    stb       = '0;
    memReq    = 1'b0;
    memWe     = 1'b0;
    frmValid  = 1'b0;
    case (state)
      ST_IDLE: begin
        stb.timerRun = 1'b1;
        if (engEnable && pollDue) begin
          stb.fetchStart = 1'b1;
          stateNext      = ST_RD_INFO;
        end
      end
      ST_RD_INFO: begin
        memReq = 1'b1;
        if (memAck) begin
          stb.latchInfo = 1'b1;
          stateNext     = infoOwn ? ST_RD_PTR : ST_IDLE;
        end
      end
      ST_RD_PTR: begin
        memReq     = 1'b1;
        stb.selPtr = 1'b1;
        if (memAck) begin
          stb.latchPtr = 1'b1;
          stateNext    = ST_SEND;
        end
      end
      ST_SEND: begin
        frmValid = 1'b1;
        if (frmReady) stateNext = ST_WAIT;
      end
      ST_WAIT: begin
        if (frmDone) begin
          stb.mergeStatus = 1'b1;
          stateNext       = ST_WB;
        end
      end
      ST_WB: begin
        memReq = 1'b1;
        memWe  = 1'b1;
        if (memAck) begin
          stb.advance = 1'b1;
          stateNext   = engEnable ? ST_RD_INFO : ST_IDLE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/txring_engine.sv
module txring_engine
  import txr_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 8,
  parameter int LEN_W  = 11,
  parameter int TMR_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [1:0]        regAddr,
  input  logic [31:0]       regWrData,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [31:0]       memWData,
  input  logic [31:0]       memRData,
  input  logic              memAck,
  output logic              frmValid,
  output logic [ADDR_W-1:0] frmAddr,
  output logic [LEN_W-1:0]  frmLen,
  input  logic              frmReady,
  input  logic              frmDone,
  input  logic [3:0]        frmStatus,
  output logic              txIrq
);

  txrStrobe_t stb;
  logic       engEnable, pollDue, infoOwn;

  txr_datapath #(
    .ADDR_W(ADDR_W), .IDX_W(IDX_W), .LEN_W(LEN_W), .TMR_W(TMR_W)
  ) u_dp (
    .clk(clk), .rstN(rstN),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .memRData(memRData), .frmStatus(frmStatus), .stb(stb),
    .engEnable(engEnable), .pollDue(pollDue), .infoOwn(infoOwn),
    .memAddr(memAddr), .memWData(memWData),
    .frmAddr(frmAddr), .frmLen(frmLen), .txIrq(txIrq)
  );

  txr_control u_ctl (
    .clk(clk), .rstN(rstN),
    .engEnable(engEnable), .pollDue(pollDue), .infoOwn(infoOwn),
    .memAck(memAck), .frmReady(frmReady), .frmDone(frmDone),
    .memReq(memReq), .memWe(memWe), .frmValid(frmValid), .stb(stb)
  );

endmodule

// File: rtl/txring_checker.sv
module txring_checker #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 11
) (
  input logic              clk,
  input logic              rstN,
  input logic              regWrEn,
  input logic [1:0]        regAddr,
  input logic [31:0]       regWrData,
  input logic              memReq,
  input logic              memWe,
  input logic              memAck,
  input logic [ADDR_W-1:0] memAddr,
  input logic [31:0]       memWData,
  input logic              frmValid,
  input logic              frmReady,
  input logic [ADDR_W-1:0] frmAddr,
  input logic [LEN_W-1:0]  frmLen,
  input logic              txIrq,
  input logic              engEnable
);

  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memAck |=> memReq && $stable(memAddr) && $stable(memWe) && $stable(memWData)); // R10

  AST_FRM_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    frmValid && !frmReady |=> frmValid && $stable(frmAddr) && $stable(frmLen)); // R10

  AST_ONE_SIDE: assert property (@(posedge clk) disable iff (!rstN)
    frmValid |-> !memReq); // R10

  AST_WB_OWN_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    memReq && memWe |-> !memWData[31]); // R3

  AST_FETCH_ENABLED: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memReq) |-> $past(engEnable)); // R8

  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txIrq) |-> $past(memReq && memWe && memAck)); // R9

  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    txIrq && !(regWrEn && regAddr == 2'd3 && regWrData[0]) |=> txIrq); // R9

endmodule

bind txring_engine txring_checker #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_chk (
  .clk(clk), .rstN(rstN),
  .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
  .memReq(memReq), .memWe(memWe), .memAck(memAck),
  .memAddr(memAddr), .memWData(memWData),
  .frmValid(frmValid), .frmReady(frmReady),
  .frmAddr(frmAddr), .frmLen(frmLen),
  .txIrq(txIrq), .engEnable(engEnable)
);

// File: tb/txring_engine_bench.sv
module txring_engine_bench;

  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] BASE = 32'h0000_0100;
  localparam int BASE_WORD = 64;

  logic        clk = 1'b0;
  logic        rstN;
  logic        regWrEn;
  logic [1:0]  regAddr;
  logic [31:0] regWrData;
  logic        memReq, memWe, memAck;
  logic [31:0] memAddr, memWData, memRData;
  logic        frmValid, frmReady, frmDone;
  logic [31:0] frmAddr;
  logic [10:0] frmLen;
  logic [3:0]  frmStatus;
  logic        txIrq;

  logic [31:0] mem [0:255];
  logic [31:0] logAddr [0:15];
  logic [10:0] logLen [0:15];
  int          frmCount, ackCount, doneCnt;
  logic [3:0]  nextErr;
  int          vectors = 0, miscompares = 0;
  bit          finished = 1'b0;

  txring_engine u_txring_engine (
    .clk(clk), .rstN(rstN),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .memReq(memReq), .memWe(memWe), .memAddr(memAddr), .memWData(memWData),
    .memRData(memRData), .memAck(memAck),
    .frmValid(frmValid), .frmAddr(frmAddr), .frmLen(frmLen),
    .frmReady(frmReady), .frmDone(frmDone), .frmStatus(frmStatus),
    .txIrq(txIrq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Memory responder: one-cycle ack pulse per request
  always @(posedge clk) begin
    if (!rstN) begin
      memAck   <= 1'b0;
      memRData <= '0;
      ackCount <= 0;
    end else if (memReq && !memAck) begin
      memAck   <= 1'b1;
      ackCount <= ackCount + 1;
      if (memWe) mem[memAddr[9:2]] <= memWData;
      else       memRData <= mem[memAddr[9:2]];
    end else begin
      memAck <= 1'b0;
    end
  end

  // Frame responder: accept, then finish three cycles later
  always @(posedge clk) begin
    if (!rstN) begin
      frmReady  <= 1'b0;
      frmDone   <= 1'b0;
      frmStatus <= '0;
      doneCnt   <= 0;
      frmCount  <= 0;
    end else begin
      frmReady <= 1'b0;
      frmDone  <= 1'b0;
      if (frmValid && !frmReady && doneCnt == 0) begin
        frmReady                <= 1'b1;
        logAddr[frmCount[3:0]]  <= frmAddr;
        logLen[frmCount[3:0]]   <= frmLen;
        frmCount                <= frmCount + 1;
        doneCnt                 <= 3;
      end else if (doneCnt != 0) begin
        doneCnt <= doneCnt - 1;
        if (doneCnt == 1) begin
          frmDone   <= 1'b1;
          frmStatus <= nextErr;
        end
      end
    end
  end

  function automatic logic [31:0] mkInfo(input logic own, input logic [10:0] len);
    return {own, 2'b11, 18'd0, len};
  endfunction

  function automatic logic [31:0] ctrlWord(input logic en);
    return {8'd0, 8'd4, 15'd0, en};
  endfunction

  task automatic setDesc(input int i, input logic own, input logic [10:0] len,
                         input logic [31:0] ptr);
    mem[BASE_WORD + 2*i]     = mkInfo(own, len);
    mem[BASE_WORD + 2*i + 1] = ptr;
  endtask

  task automatic regWrite(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn   = 1'b1;
    regAddr   = a;
    regWrData = d;
    @(negedge clk);
    regWrEn   = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R1 memReq", {31'd0, memReq}, 32'd0);
    chk("R1 frmValid", {31'd0, frmValid}, 32'd0);
    chk("R1 txIrq", {31'd0, txIrq}, 32'd0);
  endtask

  task automatic t_basic;
    setDesc(0, 1'b1, 11'd60,  32'h0000_A000);
    setDesc(1, 1'b1, 11'd100, 32'h0000_B000);
    setDesc(2, 1'b0, 11'd70,  32'h0000_C000);
    setDesc(3, 1'b0, 11'd80,  32'h0000_D000);
    setDesc(4, 1'b1, 11'd99,  32'h0000_EEEE);
    regWrite(2'd1, BASE);
    regWrite(2'd2, 32'd1000);
    regWrite(2'd0, ctrlWord(1'b1));
    idle(100);
    chk("R2 frame count", frmCount, 2);
    chk("R2 frame0 addr", logAddr[0], 32'h0000_A000);
    chk("R2 frame0 len", {21'd0, logLen[0]}, 32'd60);
    chk("R2 frame1 addr", logAddr[1], 32'h0000_B000);
    chk("R2 frame1 len", {21'd0, logLen[1]}, 32'd100);
    chk("R3 slot0 writeback", mem[BASE_WORD], mkInfo(1'b0, 11'd60));
    chk("R3 slot1 writeback", mem[BASE_WORD + 2], mkInfo(1'b0, 11'd100));
    chk("R4 slot2 untouched", mem[BASE_WORD + 4], mkInfo(1'b0, 11'd70));
    chk("R9 irq set", {31'd0, txIrq}, 32'd1);
    regWrite(2'd3, 32'h1);
    @(negedge clk);
    chk("R9 irq cleared", {31'd0, txIrq}, 32'd0);
  endtask

  task automatic t_kick;
    nextErr = 4'b1010;
    setDesc(2, 1'b1, 11'd70, 32'h0000_C000);
    idle(200);
    chk("R6 no early repoll", frmCount, 2);
    regWrite(2'd3, 32'h2);
    idle(40);
    chk("R7 kick fetch", frmCount, 3);
    chk("R4 resumed slot addr", logAddr[2], 32'h0000_C000);
    chk("R3 status merge", mem[BASE_WORD + 4], mkInfo(1'b0, 11'd70) | 32'h000A_0000);
    chk("R9 irq on error frame", {31'd0, txIrq}, 32'd1);
    nextErr = 4'b0000;
  endtask

  task automatic t_wrap;
    setDesc(3, 1'b1, 11'd80, 32'h0000_D000);
    regWrite(2'd3, 32'h2);
    idle(40);
    chk("R5 slot3 sent", frmCount, 4);
    chk("R5 slot3 len", {21'd0, logLen[3]}, 32'd80);
    chk("R5 decoy slot4 unused", mem[BASE_WORD + 8], mkInfo(1'b1, 11'd99));
    regWrite(2'd2, 32'd30);
    regWrite(2'd3, 32'h2);
    idle(10);
    setDesc(0, 1'b1, 11'd61, 32'h0000_A100);
    idle(150);
    chk("R6 timed repoll", frmCount, 5);
    chk("R5 wrapped to slot0", {21'd0, logLen[4]}, 32'd61);
  endtask

  task automatic t_enable;
    int acksBefore;
    regWrite(2'd0, ctrlWord(1'b0));
    idle(5);
    acksBefore = ackCount;
    setDesc(1, 1'b1, 11'd101, 32'h0000_B100);
    regWrite(2'd3, 32'h2);
    idle(100);
    chk("R8 no memory access disabled", ackCount, acksBefore);
    chk("R8 no frame disabled", frmCount, 5);
    setDesc(0, 1'b1, 11'd62, 32'h0000_A200);
    regWrite(2'd0, ctrlWord(1'b1));
    idle(60);
    chk("R8 frames after enable", frmCount, 7);
    chk("R8 restart at slot0", {21'd0, logLen[5]}, 32'd62);
    chk("R8 then slot1", {21'd0, logLen[6]}, 32'd101);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    rstN      = 1'b0;
    regWrEn   = 1'b0;
    regAddr   = '0;
    regWrData = '0;
    nextErr   = '0;
    for (int i = 0; i < 256; i++) mem[i] = '0;
    idle(3);
    rstN = 1'b1;
    t_reset();
    t_basic();
    t_kick();
    t_wrap();
    t_enable();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule